// File: doc/BRIEF.md
# Operate-Instruction Micro-Operation Datapath

This block carries out the register-to-register part of the "operate" instruction of an 18-bit accumulator machine. It holds three working registers: the accumulator, the memory buffer and the live register. When an operate instruction is presented with `go` high, the enabled micro-operations run in one fixed order. Each step is selected by a bit or bit field of the instruction register or of the 13-bit address field. The complete result is captured on one rising clock edge.

Each step works on the value left by the step before it, not on the register values at the start of the cycle. Two cases follow from this. When the live-register transfer and the buffer-from-live-register transfer are requested together, the two registers exchange their values as they stood at that point of the sequence. The carry step adds with the carry out of the top bit folded back into the bottom bit.

Memory, instruction fetch and input/output devices sit outside this block. The surrounding control logic supplies the instruction fields, the switch words and the pen flags. It reads the three registers and the halt request from the outputs.

Top module: `opr_micro_datapath`

## Requirements
- R1: A synchronous active-low reset clears the accumulator, buffer and live registers and the halt output to zero.
- R2: Before any other step, instruction bit 2 clears accumulator bits 17..9 and instruction bit 1 clears accumulator bits 8..0.
- R3: The buffer register is zero at the start of every executed operate cycle, so with address bits 1..0 = 0 it ends the cycle at zero.
- R4: When (addr & 0o104) == 0o004, the switch word `tac` is ORed into the accumulator after the clear step.
- R5: When (addr & 0o104) == 0o100, accumulator bit 17 takes `pen[1]` and bit 16 takes `pen[0]`; the other accumulator bits are kept.
- R6: With address bits 1..0 = 1 the buffer takes the accumulator, and only after that does address bit 5 complement every accumulator bit.
- R7: With address bits 1..0 = 3, the switch word `tbr` is ORed into the buffer.
- R8: The buffer value is captured before the live-to-buffer step. Address bits 1..0 = 2 load the buffer from the live register, and address bits 8..7 = 1 load the live register from the captured value. With both, the two registers exchange.
- R9: When (addr & 0o704) == 0o104 the captured buffer value is ORed into the live register. When it equals 0o304 the captured value is ANDed into the live register, after any transfer of R8 in the same cycle.
- R10: Address bits 8..7 = 2 shift the accumulator right by one with a zero fill. Address bits 8..7 = 3 rotate it right by one, with bit 0 moving into bit 17.
- R11: Address bit 4 XORs the final buffer value into the accumulator. After that, address bit 3 XORs the buffer into the accumulator again and then adds the buffer with end-around carry.
- R12: `halt` is high for the cycle after an executed operate instruction with instruction bit 0 set and (addr & 0o17000) == 0o10000, and low otherwise.
- R13: When `go` is low, or the instruction's top two bits are not both one, all three registers keep their values and `halt` is low.
- R14: For every combination of the instruction's low three bits and address bits 8..0, the registered result equals the steps of R2 to R11 applied in their listed order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Execute the presented instruction this cycle |
| ir | input | 5 | Instruction register; operate class when bits 4..3 are 11 |
| addr | input | 13 | Address field that selects the micro-operations |
| tac | input | 18 | Switch word ORed into the accumulator |
| tbr | input | 18 | Switch word ORed into the buffer |
| pen | input | 2 | Light-pen flags |
| ac | output | 18 | Accumulator |
| mbr | output | 18 | Memory buffer register |
| lr | output | 18 | Live register |
| halt | output | 1 | Halt request for the instruction just executed |

## Verification
The hardest cases to reach are the ones where steps overlap inside a single cycle. The buffer exchange depends on the buffer having been built earlier in the same sequence. The AND into the live register comes after a transfer into that same register. The end-around carry needs a sum that runs out of the top bit. No port can load the registers directly, so the stimulus builds the states it needs with the block's own operations: a clear combined with the `tac` OR sets the accumulator, and a `tbr` load combined with the live-register transfer sets the live register. A sweep over all operate codes and all nine low address bits, fed with changing switch words, then reaches every step combination from evolving register contents.

// File: rtl/opr_pkg.sv
// Package: shared control type and field constants for the operate datapath.
// Assumes: an 18-bit word and a 13-bit address field whose bit positions are
// fixed by the instruction format.
package opr_pkg;

    localparam int ADDR_W = 13;
    localparam int IR_W   = 5;

    // One flag per micro-operation, all decoded from the instruction fields.
    typedef struct packed {
        logic clr_hi;
        logic clr_lo;
        logic pen_ld;
        logic tac_or;
        logic amb;
        logic com;
        logic tbr_or;
        logic lmb;
        logic mlr;
        logic orl;
        logic anl;
        logic shr;
        logic cyr;
        logic pad;
        logic cry;
        logic hlt;
    } opr_ctl_t;

endpackage

// File: rtl/opr_decode.sv
// Module: opr_decode
// Turns the instruction register and address field into micro-operation flags.
// Assumes: purely combinational; the class check uses the top two IR bits.
module opr_decode
    import opr_pkg::*;
(
    input  logic [IR_W-1:0]   ir,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_opr,
    output opr_ctl_t          ctl
);

    logic [1:0] lo_sel;
    logic [1:0] mid_sel;

    // Purpose: decode the operate class and each step enable.
    always_comb begin
        lo_sel      = addr[1:0];
        mid_sel     = addr[8:7];
        is_opr      = (ir[4:3] == 2'b11);
        ctl.clr_hi  = ir[2];
        ctl.clr_lo  = ir[1];
        ctl.pen_ld  = ((addr & 13'o0104) == 13'o0100);
        ctl.tac_or  = ((addr & 13'o0104) == 13'o0004);
        ctl.amb     = (lo_sel == 2'd1);
        ctl.com     = addr[5];
        ctl.tbr_or  = (lo_sel == 2'd3);
        ctl.lmb     = (lo_sel == 2'd2);
        ctl.mlr     = (mid_sel == 2'd1);
        ctl.orl     = ((addr & 13'o0704) == 13'o0104);
        ctl.anl     = ((addr & 13'o0704) == 13'o0304);
        ctl.shr     = (mid_sel == 2'd2);
        ctl.cyr     = (mid_sel == 2'd3);
        ctl.pad     = addr[4];
        ctl.cry     = addr[3];
        ctl.hlt     = ir[0] && ((addr & 13'o17000) == 13'o10000);
    end

endmodule

// File: rtl/opr_front.sv
// Module: opr_front
// First part of the sequence: half clears, pen/switch load into AC, the AC
// copy into the buffer, complement, and the switch OR into the buffer.
// Assumes: the buffer starts each executed cycle at zero.
module opr_front
    import opr_pkg::*;
#(
    parameter int W = 18
)(
    input  opr_ctl_t     ctl,
    input  logic [W-1:0] ac_in,
    input  logic [W-1:0] tac,
    input  logic [W-1:0] tbr,
    input  logic [1:0]   pen,
    output logic [W-1:0] ac_out,
    output logic [W-1:0] mbr_cap
);

    localparam int HALF = W / 2;

    logic [W-1:0] ac_clr;
    logic [W-1:0] ac_ld;
    logic [W-1:0] buf_amb;

    // Purpose: apply the front steps one after another.
    always_comb begin
        ac_clr = ac_in;
        if (ctl.clr_hi) ac_clr[W-1:HALF] = '0;
        if (ctl.clr_lo) ac_clr[HALF-1:0] = '0;

        ac_ld = ac_clr;
        if (ctl.pen_ld) ac_ld[W-1:W-2] = pen;
        if (ctl.tac_or) ac_ld = ac_ld | tac;

        buf_amb = ctl.amb ? ac_ld : '0;
        ac_out  = ctl.com ? ~ac_ld : ac_ld;
        mbr_cap = ctl.tbr_or ? (buf_amb | tbr) : buf_amb;
    end

endmodule

// File: rtl/opr_lr_xfer.sv
// Module: opr_lr_xfer
// Middle part: transfers between the buffer and the live register, plus the
// logical merges into the live register.
// Assumes: both transfers read the buffer value captured before either runs.
module opr_lr_xfer
    import opr_pkg::*;
#(
    parameter int W = 18
)(
    input  opr_ctl_t     ctl,
    input  logic [W-1:0] mbr_cap,
    input  logic [W-1:0] lr_in,
    output logic [W-1:0] mbr_out,
    output logic [W-1:0] lr_out
);

    logic [W-1:0] lr_t;

    // Purpose: move and merge words in sequence order.
    always_comb begin
        mbr_out = ctl.lmb ? lr_in : mbr_cap;
        lr_t    = ctl.mlr ? mbr_cap : lr_in;
        if (ctl.orl) lr_t = lr_t | mbr_cap;
        if (ctl.anl) lr_t = lr_t & mbr_cap;
        lr_out  = lr_t;
    end

endmodule

// File: rtl/opr_back.sv
// Module: opr_back
// Last part: shift or rotate, partial add, and the carry add with the carry
// out of the top bit wrapped into bit 0.
// Assumes: shift and rotate are exclusive by decode.
module opr_back
    import opr_pkg::*;
#(
    parameter int W = 18
)(
    input  opr_ctl_t     ctl,
    input  logic [W-1:0] ac_in,
    input  logic [W-1:0] mbr,
    output logic [W-1:0] ac_out
);

    logic [W-1:0] ac_sh;
    logic [W-1:0] ac_pad;
    logic [W-1:0] ac_x;
    logic [W:0]   raw_sum;
    logic [W-1:0] wrap_sum;

    // Purpose: one-place right shift or rotate.
    always_comb begin
        if (ctl.shr)      ac_sh = {1'b0, ac_in[W-1:1]};
        else if (ctl.cyr) ac_sh = {ac_in[0], ac_in[W-1:1]};
        else              ac_sh = ac_in;
    end

    // Purpose: half add and end-around carry add.
    always_comb begin
        ac_pad   = ctl.pad ? (ac_sh ^ mbr) : ac_sh;
        ac_x     = ac_pad ^ mbr;
        raw_sum  = {1'b0, ac_x} + {1'b0, mbr};
        wrap_sum = raw_sum[W-1:0] + {{(W-1){1'b0}}, raw_sum[W]};
        ac_out   = ctl.cry ? wrap_sum : ac_pad;
    end

endmodule

// File: rtl/opr_micro_datapath.sv
// Module: opr_micro_datapath (top)
// Holds AC, MBR and LR; on an executed operate instruction it evaluates every
// enabled micro-operation in order and registers the result on one edge.
// Assumes: synchronous active-low reset; non-operate codes leave state alone.
module opr_micro_datapath
    import opr_pkg::*;
#(
    parameter int W = 18
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [IR_W-1:0]   ir,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      tac,
    input  logic [W-1:0]      tbr,
    input  logic [1:0]        pen,
    output logic [W-1:0]      ac,
    output logic [W-1:0]      mbr,
    output logic [W-1:0]      lr,
    output logic              halt
);

    opr_ctl_t     ctl;
    logic         is_opr;
    logic         fire;
    logic [W-1:0] ac_q, mbr_q, lr_q;
    logic         halt_q;
    logic [W-1:0] ac_mid, mbr_cap, mbr_nx, lr_nx, ac_nx;

    opr_decode u_dec (
        .ir     (ir),
        .addr   (addr),
        .is_opr (is_opr),
        .ctl    (ctl)
    );

    opr_front #(.W(W)) u_front (
        .ctl     (ctl),
        .ac_in   (ac_q),
        .tac     (tac),
        .tbr     (tbr),
        .pen     (pen),
        .ac_out  (ac_mid),
        .mbr_cap (mbr_cap)
    );

    opr_lr_xfer #(.W(W)) u_xfer (
        .ctl     (ctl),
        .mbr_cap (mbr_cap),
        .lr_in   (lr_q),
        .mbr_out (mbr_nx),
        .lr_out  (lr_nx)
    );

    opr_back #(.W(W)) u_back (
        .ctl    (ctl),
        .ac_in  (ac_mid),
        .mbr    (mbr_nx),
        .ac_out (ac_nx)
    );

    assign fire = go && is_opr;

    // Purpose: register the working set and the halt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q   <= '0;
            mbr_q  <= '0;
            lr_q   <= '0;
            halt_q <= 1'b0;
        end else begin
            halt_q <= fire && ctl.hlt;
            if (fire) begin
                ac_q  <= ac_nx;
                mbr_q <= mbr_nx;
                lr_q  <= lr_nx;
            end
        end
    end

    assign ac   = ac_q;
    assign mbr  = mbr_q;
    assign lr   = lr_q;
    assign halt = halt_q;

    // R13: idle or non-operate cycles hold every register
    assert_hold_when_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(go && ir[4:3] == 2'b11) |=> ($stable(ac_q) && $stable(mbr_q) && $stable(lr_q) && !halt_q));

    // R3: buffer ends at zero when no buffer source is selected
    assert_mbr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ir[4:3] == 2'b11 && addr[1:0] == 2'd0) |=> (mbr_q == '0));

    // R8: buffer takes the previous live register value
    assert_lmb_takes_lr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ir[4:3] == 2'b11 && addr[1:0] == 2'd2) |=> (mbr_q == $past(lr_q)));

    // R12: halt only follows an executed operate with IR bit 0 and halt field
    assert_halt_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_q) |-> ($past(go) && $past(ir[0]) && $past(addr[12]) && $past(addr[11:9]) == 3'd0));

    // R2: both half clears with no other step leave AC at zero
    assert_full_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ir[4:1] == 4'b1111 && addr == '0) |=> (ac_q == '0));

endmodule

// File: tb/tb_opr_micro_datapath.sv
`timescale 1ns/1ps
module tb_opr_micro_datapath;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        go;
    logic [4:0]  ir;
    logic [12:0] addr;
    logic [17:0] tac, tbr;
    logic [1:0]  pen;
    logic [17:0] ac, mbr, lr;
    logic        halt;

    int checks = 0;
    int errors = 0;

    logic [17:0] m_ac, m_mbr, m_lr;
    logic        m_halt;
    logic [17:0] lfsr = 18'o123457;

    always #2.5 clk = ~clk;

    opr_micro_datapath dut (
        .clk(clk), .rst_n(rst_n), .go(go), .ir(ir), .addr(addr),
        .tac(tac), .tbr(tbr), .pen(pen),
        .ac(ac), .mbr(mbr), .lr(lr), .halt(halt)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%o expected=%o", tag, act, exp);
        end
    endtask

    // Expected next state computed step by step from the requirement list.
    task automatic model(input logic g, input logic [4:0] i, input logic [12:0] a,
                         input logic [17:0] t, input logic [17:0] b, input logic [1:0] p);
        logic [17:0] x, y, cap, l;
        logic [18:0] s;
        m_halt = 1'b0;
        if (g && i[4] && i[3]) begin
            x = m_ac;
            if (i[2]) x = x & 18'o000777;
            if (i[1]) x = x & 18'o777000;
            y = 18'o0;
            if ((a & 13'o104) == 13'o100) x = {p, x[15:0]};
            if ((a & 13'o104) == 13'o004) x = x | t;
            if (a[1:0] == 2'd1) y = x;
            if (a[5]) x = x ^ 18'o777777;
            if (a[1:0] == 2'd3) y = y | b;
            cap = y;
            l = m_lr;
            if (a[1:0] == 2'd2) y = l;
            if (a[8:7] == 2'd1) l = cap;
            if ((a & 13'o704) == 13'o104) l = l | cap;
            if ((a & 13'o704) == 13'o304) l = l & cap;
            if (a[8:7] == 2'd2) x = x / 2;
            if (a[8:7] == 2'd3) x = (x / 2) + (x[0] ? 18'o400000 : 18'o0);
            if (a[4]) x = x ^ y;
            if (a[3]) begin
                x = x ^ y;
                s = {1'b0, x} + {1'b0, y};
                if (s >= 19'o1000000) s = s - 19'o1000000 + 19'd1;
                x = s[17:0];
            end
            m_ac = x; m_mbr = y; m_lr = l;
            m_halt = i[0] && a[12] && (a[11:9] == 3'd0);
        end
    endtask

    task automatic op(input logic g, input logic [4:0] i, input logic [12:0] a,
                      input logic [17:0] t, input logic [17:0] b, input logic [1:0] p,
                      input string tag);
        go = g; ir = i; addr = a; tac = t; tbr = b; pen = p;
        @(negedge clk);
        model(g, i, a, t, b, p);
        check(tag, {9'd0, ac, mbr, lr, halt}, {9'd0, m_ac, m_mbr, m_lr, m_halt});
    endtask

    task automatic load_ac(input logic [17:0] v, input string tag);
        op(1'b1, 5'd30, 13'o004, v, 18'o0, 2'b00, tag);
    endtask

    function automatic logic [17:0] step_lfsr(input logic [17:0] v);
        return {v[16:0], v[17] ^ v[10]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; go = 1'b0; ir = '0; addr = '0; tac = '0; tbr = '0; pen = '0;
        m_ac = '0; m_mbr = '0; m_lr = '0; m_halt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", {9'd0, ac, mbr, lr, halt}, 64'd0);

        // R4, R2
        load_ac(18'o777777, "R4");
        check("R4 tac or", {46'd0, ac}, {46'd0, 18'o777777});
        op(1'b1, 5'd28, 13'o000, 18'o0, 18'o0, 2'b00, "R2");
        check("R2 clear high", {46'd0, ac}, {46'd0, 18'o000777});
        load_ac(18'o777777, "R2");
        op(1'b1, 5'd26, 13'o000, 18'o0, 18'o0, 2'b00, "R2");
        check("R2 clear low", {46'd0, ac}, {46'd0, 18'o777000});

        // R7, R3
        op(1'b1, 5'd24, 13'o003, 18'o0, 18'o123456, 2'b00, "R7");
        check("R7 tbr", {46'd0, mbr}, {46'd0, 18'o123456});
        op(1'b1, 5'd24, 13'o000, 18'o0, 18'o777777, 2'b00, "R3");
        check("R3 mbr zero", {46'd0, mbr}, 64'd0);

        // R5
        load_ac(18'o000777, "R5");
        op(1'b1, 5'd24, 13'o100, 18'o777777, 18'o0, 2'b10, "R5");
        check("R5 pen", {46'd0, ac}, {46'd0, 18'o400777});

        // R6
        load_ac(18'o070707, "R6");
        op(1'b1, 5'd24, 13'o041, 18'o0, 18'o0, 2'b00, "R6");
        check("R6 amb then com", {28'd0, mbr, ac}, {28'd0, 18'o070707, 18'o707070});

        // R8
        op(1'b1, 5'd24, 13'o203, 18'o0, 18'o555000, 2'b00, "R8");
        check("R8 mlr", {46'd0, lr}, {46'd0, 18'o555000});
        op(1'b1, 5'd24, 13'o202, 18'o0, 18'o0, 2'b00, "R8");
        check("R8 exchange", {28'd0, mbr, lr}, {28'd0, 18'o555000, 18'o000000});

        // R9
        op(1'b1, 5'd24, 13'o203, 18'o0, 18'o000777, 2'b00, "R9");
        op(1'b1, 5'd24, 13'o107, 18'o0, 18'o770000, 2'b00, "R9");
        check("R9 orl", {46'd0, lr}, {46'd0, 18'o770777});
        op(1'b1, 5'd24, 13'o307, 18'o0, 18'o707070, 2'b00, "R9");
        check("R9 anl after mlr", {46'd0, lr}, {46'd0, 18'o707070});

        // R10
        load_ac(18'o000001, "R10");
        op(1'b1, 5'd24, 13'o600, 18'o0, 18'o0, 2'b00, "R10");
        check("R10 rotate", {46'd0, ac}, {46'd0, 18'o400000});
        op(1'b1, 5'd24, 13'o400, 18'o0, 18'o0, 2'b00, "R10");
        check("R10 shift", {46'd0, ac}, {46'd0, 18'o200000});

        // R11
        load_ac(18'o777000, "R11");
        op(1'b1, 5'd24, 13'o023, 18'o0, 18'o707070, 2'b00, "R11");
        check("R11 pad", {46'd0, ac}, {46'd0, 18'o070070});
        load_ac(18'o400000, "R11");
        op(1'b1, 5'd24, 13'o013, 18'o0, 18'o600000, 2'b00, "R11");
        check("R11 carry wrap", {46'd0, ac}, {46'd0, 18'o000001});

        // R12
        op(1'b1, 5'd25, 13'o10000, 18'o0, 18'o0, 2'b00, "R12");
        check("R12 halt set", {63'd0, halt}, 64'd1);
        op(1'b1, 5'd24, 13'o10000, 18'o0, 18'o0, 2'b00, "R12");
        check("R12 no ir0", {63'd0, halt}, 64'd0);
        op(1'b1, 5'd25, 13'o11000, 18'o0, 18'o0, 2'b00, "R12");
        check("R12 wrong field", {63'd0, halt}, 64'd0);
        for (int i = 24; i < 32; i++)
            for (int h = 0; h < 16; h++)
                op(1'b1, 5'(i), {4'(h), 9'o003}, 18'o0, 18'(h * 4097), 2'b00, "R12");

        // R13
        load_ac(18'o135246, "R13");
        op(1'b0, 5'd31, 13'o10041, 18'o777777, 18'o777777, 2'b11, "R13");
        check("R13 go low", {10'd0, ac, mbr, halt, 17'd0}, {10'd0, 18'o135246, 18'o000000, 1'b0, 17'd0});
        for (int i = 0; i < 24; i++)
            op(1'b1, 5'(i), 13'(i * 331), 18'o777777, 18'o777777, 2'b11, "R13");
        check("R13 non-operate", {46'd0, ac}, {46'd0, 18'o135246});

        // R14: every low IR combination against every low address pattern
        for (int pass = 0; pass < 2; pass++)
            for (int i = 24; i < 32; i++)
                for (int a = 0; a < 512; a++) begin
                    lfsr = step_lfsr(lfsr);
                    op(1'b1, 5'(i), 13'(a), lfsr, {lfsr[8:0], lfsr[17:9]} ^ 18'(pass * 18'o252525),
                       2'(a + pass), "R14");
                end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule